// File: doc/BRIEF.md
# Unary Fuse Counter Manager

This block keeps two one-time-programmable counters, each stored as a thermometer-coded row of fuse bits: a firmware version counter and a safe-mode counter. A counter's value is the number of burned bits. The parity of the version counter chooses which of two firmware slots is booted, so no separate pointer is stored. The parity of the safe-mode counter keeps the safe-mode flag across power cycles. Entering safe mode burns one bit and gives an odd count. Leaving it after recovery burns one more bit and gives an even count.

Each counter has an increment request. The request is acknowledged for one cycle after a fixed programming latency, and a successful increment burns exactly the next fuse. A raw burn mask per counter models direct fuse programming. It can only set bits. A row that is no longer a valid thermometer code is reported as tampering and forces safe mode. A combinational gate judges a proposed new firmware version against the current count for rollback protection. A parameter selects either strictly-greater or exactly-one-more acceptance. The fuse rows are cleared by reset, which models a fresh part.

Top module: `fuse_ctr_mgr`

## Requirements
- R1: After reset both counts are 0, `boot_slot_b`, `safe_mode`, `tamper`, both exhausted flags and both acknowledges are 0.
- R2: An accepted increment (`*_inc_ok`=1) burns exactly one fuse, so the count seen in the acknowledge cycle is one above the count before.
- R3: A request sampled at a clock edge while that counter is idle is acknowledged by `*_inc_ack`=1 for exactly one cycle, visible after the PROG_LAT-th following edge. Requests made while the counter is busy are ignored.
- R4: `boot_slot_b` is 1 (slot B) when the version count is odd and 0 (slot A) when it is even.
- R5: `safe_mode` is 1 when the safe-mode count is odd and 0 when it is even, if no tamper is flagged. Two increments enter safe mode and then leave it.
- R6: A burn mask bit of 1 sets that fuse (bit i of the mask is fuse i, fuse 0 is the lowest). A mask bit of 0 never clears a fuse. Each count equals the number of set fuses and never decreases.
- R7: If either fuse row has a set bit above a clear bit, `tamper` is 1 and `safe_mode` is forced to 1.
- R8: A counter with all fuses set raises its exhausted flag. An increment request to it is acknowledged with `*_inc_ok`=0 and leaves the count unchanged.
- R9: With SINGLE_STEP=1, `prop_ok` is 1 only when `prop_ver` equals the version count plus one. With SINGLE_STEP=0, it is 1 only when `prop_ver` is greater than the version count.
- R10: When an increment completes on the same edge as a burn mask is applied to that counter, both take effect: the row becomes the union of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the fuse model |
| ver_inc_req | input | 1 | Request one version increment |
| safe_inc_req | input | 1 | Request one safe-mode increment |
| ver_burn_mask | input | VER_BITS | Raw fuse set mask, version row |
| safe_burn_mask | input | SAFE_BITS | Raw fuse set mask, safe-mode row |
| prop_ver | input | $clog2(VER_BITS+1) | Proposed new version |
| ver_count | output | $clog2(VER_BITS+1) | Version count |
| safe_count | output | $clog2(SAFE_BITS+1) | Safe-mode count |
| boot_slot_b | output | 1 | 1 selects slot B, 0 selects slot A |
| safe_mode | output | 1 | Safe-mode flag |
| tamper | output | 1 | A fuse row is not a thermometer code |
| ver_exhausted | output | 1 | All version fuses used |
| safe_exhausted | output | 1 | All safe-mode fuses used |
| ver_inc_ack | output | 1 | Version increment finished, one cycle |
| ver_inc_ok | output | 1 | Qualifies ver_inc_ack: 1 burned, 0 rejected |
| safe_inc_ack | output | 1 | Safe-mode increment finished, one cycle |
| safe_inc_ok | output | 1 | Qualifies safe_inc_ack: 1 burned, 0 rejected |
| prop_ok | output | 1 | Proposed version is acceptable |

## Verification
The completion of a requested increment and a raw burn mask can hit the same fuse row on the same clock edge. The bench provokes this by starting a version increment and then applying a mask on the bit just above the one the increment will burn. The mask is held exactly across the completing edge. The result is judged in the acknowledge cycle: the count must have grown by two, the row must still be a valid thermometer code, and no tamper may be reported. This also shows that neither write masked the other.

// File: rtl/fuse_ctr_pkg.sv
package fuse_ctr_pkg;
   localparam int MAX_FUSES = 64;

   typedef struct packed {
      logic ack;
      logic ok;
   } inc_resp_t;
endpackage

// File: rtl/fuse_bank.sv
module fuse_bank
   import fuse_ctr_pkg::*;
#(
   parameter int N   = 16,
   parameter int LAT = 3,
   localparam int CW  = $clog2(N + 1),
   localparam int LCW = (LAT > 1) ? $clog2(LAT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_req,
   input  logic [N-1:0]  burn_mask,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          thermo_ok,
   output inc_resp_t     resp
);
   logic [N-1:0]   row_q;
   logic [N-1:0]   row_d;
   logic [N-1:0]   next_bit_row;
   logic           busy_q;
   logic [LCW-1:0] wait_q;
   logic           finish;

   // lowest clear bit set; equals the next thermometer step on a valid row
   assign next_bit_row = row_q | (row_q + N'(1));
   assign full         = &row_q;
   assign thermo_ok    = ((row_q & (row_q + N'(1))) == '0);
   assign finish       = busy_q && (wait_q == '0);

   always_comb begin
      row_d = row_q | burn_mask;
      if (finish && !full) row_d = row_d | next_bit_row;
   end

   always_comb begin
      count = '0;
      for (int i = 0; i < N; i++) count = count + CW'(row_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= '0;
         busy_q  <= 1'b0;
         wait_q  <= '0;
         resp    <= '0;
      end else begin
         row_q    <= row_d;
         resp.ack <= finish;
         resp.ok  <= finish && !full;
         if (finish) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            wait_q <= wait_q - LCW'(1);
         end else if (inc_req) begin
            busy_q <= 1'b1;
            wait_q <= LCW'(LAT - 1);
         end
      end
   end
endmodule

// File: rtl/fuse_ver_gate.sv
module fuse_ver_gate #(
   parameter int CW          = 5,
   parameter bit SINGLE_STEP = 1'b1
) (
   input  logic [CW-1:0] cur,
   input  logic [CW-1:0] prop,
   output logic          ok
);
   generate
      if (SINGLE_STEP) begin : g_step
         assign ok = ({1'b0, prop} == ({1'b0, cur} + (CW+1)'(1)));
      end else begin : g_mono
         assign ok = (prop > cur);
      end
   endgenerate
endmodule

// File: rtl/fuse_ctr_mgr.sv
module fuse_ctr_mgr
   import fuse_ctr_pkg::*;
#(
   parameter int VER_BITS    = 16,
   parameter int SAFE_BITS   = 8,
   parameter int PROG_LAT    = 3,
   parameter bit SINGLE_STEP = 1'b1,
   localparam int VCW = $clog2(VER_BITS + 1),
   localparam int SCW = $clog2(SAFE_BITS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ver_inc_req,
   input  logic                 safe_inc_req,
   input  logic [VER_BITS-1:0]  ver_burn_mask,
   input  logic [SAFE_BITS-1:0] safe_burn_mask,
   input  logic [VCW-1:0]       prop_ver,
   output logic [VCW-1:0]       ver_count,
   output logic [SCW-1:0]       safe_count,
   output logic                 boot_slot_b,
   output logic                 safe_mode,
   output logic                 tamper,
   output logic                 ver_exhausted,
   output logic                 safe_exhausted,
   output logic                 ver_inc_ack,
   output logic                 ver_inc_ok,
   output logic                 safe_inc_ack,
   output logic                 safe_inc_ok,
   output logic                 prop_ok
);
   generate
      if (VER_BITS < 1 || VER_BITS > MAX_FUSES) begin : g_bad_ver
         $error("VER_BITS out of range");
      end
      if (SAFE_BITS < 1 || SAFE_BITS > MAX_FUSES) begin : g_bad_safe
         $error("SAFE_BITS out of range");
      end
      if (PROG_LAT < 1) begin : g_bad_lat
         $error("PROG_LAT must be at least 1");
      end
   endgenerate

   inc_resp_t ver_resp;
   inc_resp_t safe_resp;
   logic      ver_thermo;
   logic      safe_thermo;

   fuse_bank #(.N(VER_BITS), .LAT(PROG_LAT)) i_ver_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_req   (ver_inc_req),
      .burn_mask (ver_burn_mask),
      .count     (ver_count),
      .full      (ver_exhausted),
      .thermo_ok (ver_thermo),
      .resp      (ver_resp)
   );

   fuse_bank #(.N(SAFE_BITS), .LAT(PROG_LAT)) i_safe_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_req   (safe_inc_req),
      .burn_mask (safe_burn_mask),
      .count     (safe_count),
      .full      (safe_exhausted),
      .thermo_ok (safe_thermo),
      .resp      (safe_resp)
   );

   fuse_ver_gate #(.CW(VCW), .SINGLE_STEP(SINGLE_STEP)) i_gate (
      .cur  (ver_count),
      .prop (prop_ver),
      .ok   (prop_ok)
   );

   assign tamper       = !(ver_thermo && safe_thermo);
   assign boot_slot_b  = ver_count[0];
   assign safe_mode    = safe_count[0] | tamper;
   assign ver_inc_ack  = ver_resp.ack;
   assign ver_inc_ok   = ver_resp.ok;
   assign safe_inc_ack = safe_resp.ack;
   assign safe_inc_ok  = safe_resp.ok;
endmodule

// File: rtl/fuse_ctr_mgr_chk.sv
module fuse_ctr_mgr_chk #(
   parameter int VER_BITS  = 16,
   parameter int SAFE_BITS = 8,
   localparam int VCW = $clog2(VER_BITS + 1),
   localparam int SCW = $clog2(SAFE_BITS + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [VER_BITS-1:0] ver_burn_mask,
   input logic [VCW-1:0]      ver_count,
   input logic [SCW-1:0]      safe_count,
   input logic                safe_mode,
   input logic                tamper,
   input logic                ver_exhausted,
   input logic                ver_inc_ack,
   input logic                ver_inc_ok,
   input logic                safe_inc_ack
);
   // R3: acknowledge is a single-cycle pulse
   p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ver_inc_ack |=> !ver_inc_ack);
   p_safe_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      safe_inc_ack |=> !safe_inc_ack);

   // R2: an accepted increment without a concurrent burn adds exactly one
   p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ver_inc_ack && ver_inc_ok && $past(ver_burn_mask) == '0)
      |-> ver_count == $past(ver_count) + VCW'(1));

   // R6: counts never decrease
   p_ver_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ver_count >= $past(ver_count));
   p_safe_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      safe_count >= $past(safe_count));

   // R8: a rejected increment only happens on a full row and changes nothing
   p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ver_inc_ack && !ver_inc_ok) |-> ver_exhausted);
   p_reject_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ver_inc_ack && !ver_inc_ok && $past(ver_burn_mask) == '0)
      |-> $stable(ver_count));

   // R7: tamper forces safe mode
   p_tamper_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tamper |-> safe_mode);
endmodule

bind fuse_ctr_mgr fuse_ctr_mgr_chk #(.VER_BITS(VER_BITS), .SAFE_BITS(SAFE_BITS)) i_fuse_ctr_mgr_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ver_burn_mask (ver_burn_mask),
   .ver_count     (ver_count),
   .safe_count    (safe_count),
   .safe_mode     (safe_mode),
   .tamper        (tamper),
   .ver_exhausted (ver_exhausted),
   .ver_inc_ack   (ver_inc_ack),
   .ver_inc_ok    (ver_inc_ok),
   .safe_inc_ack  (safe_inc_ack)
);

// File: tb/test_fuse_ctr_mgr.sv
`timescale 1ns/1ps
module test_fuse_ctr_mgr;
   localparam int VB  = 16;
   localparam int SB  = 8;
   localparam int LAT = 3;
   localparam int VCW = $clog2(VB + 1);
   localparam int SCW = $clog2(SB + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ver_inc_req = 1'b0;
   logic safe_inc_req = 1'b0;
   logic [VB-1:0] ver_burn_mask = '0;
   logic [SB-1:0] safe_burn_mask = '0;
   logic [VCW-1:0] prop_ver = '0;

   logic [VCW-1:0] ver_count, g_ver_count;
   logic [SCW-1:0] safe_count, g_safe_count;
   logic boot_slot_b, safe_mode, tamper, ver_exhausted, safe_exhausted;
   logic ver_inc_ack, ver_inc_ok, safe_inc_ack, safe_inc_ok, prop_ok;
   logic g_slot, g_safe, g_tamper, g_vex, g_sex, g_vack, g_vok, g_sack, g_sok, g_prop_ok;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fuse_ctr_mgr #(.VER_BITS(VB), .SAFE_BITS(SB), .PROG_LAT(LAT), .SINGLE_STEP(1'b1)) i_fuse_ctr_mgr (
      .clk(clk), .rst_n(rst_n), .ver_inc_req(ver_inc_req), .safe_inc_req(safe_inc_req),
      .ver_burn_mask(ver_burn_mask), .safe_burn_mask(safe_burn_mask), .prop_ver(prop_ver),
      .ver_count(ver_count), .safe_count(safe_count), .boot_slot_b(boot_slot_b),
      .safe_mode(safe_mode), .tamper(tamper), .ver_exhausted(ver_exhausted),
      .safe_exhausted(safe_exhausted), .ver_inc_ack(ver_inc_ack), .ver_inc_ok(ver_inc_ok),
      .safe_inc_ack(safe_inc_ack), .safe_inc_ok(safe_inc_ok), .prop_ok(prop_ok));

   // second instance in strictly-greater mode, same stimulus
   fuse_ctr_mgr #(.VER_BITS(VB), .SAFE_BITS(SB), .PROG_LAT(LAT), .SINGLE_STEP(1'b0)) i_fuse_ctr_mgr_gt (
      .clk(clk), .rst_n(rst_n), .ver_inc_req(ver_inc_req), .safe_inc_req(safe_inc_req),
      .ver_burn_mask(ver_burn_mask), .safe_burn_mask(safe_burn_mask), .prop_ver(prop_ver),
      .ver_count(g_ver_count), .safe_count(g_safe_count), .boot_slot_b(g_slot),
      .safe_mode(g_safe), .tamper(g_tamper), .ver_exhausted(g_vex),
      .safe_exhausted(g_sex), .ver_inc_ack(g_vack), .ver_inc_ok(g_vok),
      .safe_inc_ack(g_sack), .safe_inc_ok(g_sok), .prop_ok(g_prop_ok));

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // pulse a request for one edge, return observed latency and ok
   task automatic run_inc(input bit safe, output int lat, output bit ok);
      lat = -1; ok = 1'b0;
      @(negedge clk);
      if (safe) safe_inc_req = 1'b1; else ver_inc_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ver_inc_req = 1'b0; safe_inc_req = 1'b0;
      for (int k = 1; k <= 20; k++) begin
         @(posedge clk);
         @(negedge clk);
         if ((safe ? safe_inc_ack : ver_inc_ack) && lat < 0) begin
            lat = k;
            ok = safe ? safe_inc_ok : ver_inc_ok;
            break;
         end
      end
   endtask

   task automatic burn(input logic [VB-1:0] vm, input logic [SB-1:0] sm);
      @(negedge clk);
      ver_burn_mask = vm; safe_burn_mask = sm;
      @(posedge clk);
      @(negedge clk);
      ver_burn_mask = '0; safe_burn_mask = '0;
   endtask

   task automatic t_reset;
      chk("R1", "ver_count", ver_count, 0);
      chk("R1", "safe_count", safe_count, 0);
      chk("R1", "boot_slot_b", boot_slot_b, 0);
      chk("R1", "safe_mode", safe_mode, 0);
      chk("R1", "tamper", tamper, 0);
      chk("R1", "exhausted", {ver_exhausted, safe_exhausted}, 0);
      chk("R1", "acks", {ver_inc_ack, safe_inc_ack}, 0);
   endtask

   task automatic t_ver_steps;
      int lat; bit ok;
      run_inc(1'b0, lat, ok);
      chk("R3", "latency", lat, LAT);
      chk("R2", "ok", ok, 1);
      chk("R2", "count after 1st", ver_count, 1);
      chk("R4", "slot odd", boot_slot_b, 1);
      @(negedge clk);
      chk("R3", "ack one cycle", ver_inc_ack, 0);
      run_inc(1'b0, lat, ok);
      chk("R2", "count after 2nd", ver_count, 2);
      chk("R4", "slot even", boot_slot_b, 0);
   endtask

   task automatic t_busy_ignore;
      int acks = 0;
      @(negedge clk); ver_inc_req = 1'b1;
      @(posedge clk);
      @(negedge clk); // busy now, keep requesting
      @(posedge clk);
      @(negedge clk); ver_inc_req = 1'b0;
      for (int k = 0; k < 12; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (ver_inc_ack) acks++;
      end
      chk("R3", "acks for busy repeat", acks, 1);
      chk("R3", "count after busy repeat", ver_count, 3);
   endtask

   task automatic t_gate;
      prop_ver = VCW'(4); #1;
      chk("R9", "step next", prop_ok, 1);
      chk("R9", "gt next", g_prop_ok, 1);
      prop_ver = VCW'(5); #1;
      chk("R9", "step skip", prop_ok, 0);
      chk("R9", "gt skip", g_prop_ok, 1);
      prop_ver = VCW'(3); #1;
      chk("R9", "step equal", prop_ok, 0);
      chk("R9", "gt equal", g_prop_ok, 0);
      prop_ver = VCW'(2); #1;
      chk("R9", "gt rollback", g_prop_ok, 0);
      prop_ver = '0;
   endtask

   task automatic t_burn;
      burn(16'h0001, '0);
      chk("R6", "mask on set bit", ver_count, 3);
      burn(16'h0008, '0);
      chk("R6", "mask new bit", ver_count, 4);
      chk("R6", "no tamper", tamper, 0);
   endtask

   task automatic t_collide;
      @(negedge clk); ver_inc_req = 1'b1;
      @(posedge clk);
      @(negedge clk); ver_inc_req = 1'b0;
      for (int k = 1; k < LAT; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
      ver_burn_mask = 16'h0020;
      @(posedge clk);
      @(negedge clk);
      ver_burn_mask = '0;
      chk("R10", "ack at collide", ver_inc_ack, 1);
      chk("R10", "count union", ver_count, 6);
      chk("R10", "no tamper", tamper, 0);
      chk("R4", "slot after 6", boot_slot_b, 0);
   endtask

   task automatic t_exhaust;
      int lat; bit ok;
      chk("R8", "not yet exhausted", ver_exhausted, 0);
      burn('1, '0);
      chk("R8", "full count", ver_count, VB);
      chk("R8", "exhausted", ver_exhausted, 1);
      run_inc(1'b0, lat, ok);
      chk("R8", "reject ack latency", lat, LAT);
      chk("R8", "reject ok", ok, 0);
      chk("R8", "count held", ver_count, VB);
   endtask

   task automatic t_safe;
      int lat; bit ok;
      run_inc(1'b1, lat, ok);
      chk("R3", "safe latency", lat, LAT);
      chk("R5", "safe count 1", safe_count, 1);
      chk("R5", "enter safe", safe_mode, 1);
      run_inc(1'b1, lat, ok);
      chk("R5", "safe count 2", safe_count, 2);
      chk("R5", "leave safe", safe_mode, 0);
   endtask

   task automatic t_tamper;
      burn('0, 8'h60);
      chk("R7", "safe count", safe_count, 4);
      chk("R7", "tamper", tamper, 1);
      chk("R7", "forced safe", safe_mode, 1);
      chk("R8", "safe not exhausted", safe_exhausted, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_ver_steps();
      t_busy_ignore();
      t_gate();
      t_burn();
      t_collide();
      t_exhaust();
      t_safe();
      t_tamper();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule